// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Triggers

This block is a bus-attached general-purpose I/O peripheral for up to 32 pins. Software reaches it through a simple synchronous read/write port that addresses 32-bit registers on word boundaries. Each pin can be an input or an output. Output pins drive the value register. Input pins are brought into the clock domain by a two-flop synchronizer before any use.

Every pin can raise an interrupt. Three per-pin configuration bits set the trigger: a trigger-kind bit (level or edge), a sense bit (high/rising or low/falling) and an any-edge bit. Matching events latch into a sticky status register. A write-one-to-clear register releases those latched bits. An enable register masks status into a pending view, and the pending bits are OR-ed into a single interrupt line. A version register tells software whether the any-edge option is built in.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, direction reads all ones (every pin an input), enable reads 0, trigger-kind reads 0 (level), sense reads all ones (active-high), any-edge reads 0, pin_oe and pin_out are 0, irq_out is low and status reads 0 while pins are low.
- R2: pin_out always equals the value register. pin_oe bit n is 1 exactly when direction bit n is 0. A direction bit of 1 makes the pin an input. pin_out changes only on a bus write.
- R3: Register word offsets are: value 0x00, direction 0x04, enable 0x08, status 0x0C, pending 0x10, clear 0x14, trigger-kind 0x18, sense 0x1C, version 0x20, any-edge 0x24. A read of value returns the synchronized pin level for input pins and the value register bit for output pins. A pin change becomes visible in the value read after two clocks.
- R4: With trigger-kind 0, a status bit latches while the synchronized pin equals its sense bit (sense 1 is active-high, sense 0 is active-low).
- R5: With trigger-kind 1 and any-edge 0, a status bit latches on a rising edge when sense is 1 and on a falling edge when sense is 0. An edge is found by comparing the synchronized sample with the previous cycle's sample.
- R6: The version register reads the VERSION parameter (default 3). When VERSION is 3 or more, any-edge is writable, and a pin with both trigger-kind and any-edge set latches on either transition.
- R7: Writing 1 to a bit of the clear register clears that status bit. Writing 0 has no effect. An event in the same cycle as the clear wins, and a level that is still active keeps the bit set.
- R8: Pending reads status AND enable. irq_out is high exactly when any pending bit is set. Writing 0 to enable masks every pin.
- R9: Status bits are sticky: they fall only through a clear write. Writes to the status, pending and version offsets have no effect.
- R10: Read data appears on bus_rdata on the clock after bus_rd is sampled and holds while bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address; bits [5:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Asynchronous pin levels from the pads |
| pin_out | output | NUM_PINS | Output levels toward the pads |
| pin_oe | output | NUM_PINS | Output enable per pin (1 = drive) |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The main sweep runs eight trigger configurations. Each one mixes level, single-edge and any-edge pins with both sense values, drawn as rotated bit patterns so that every pin sees every mode. Each configuration then applies a dozen arithmetic pin sequences. The sequences are chosen so that a wrong sense, a missed edge, or an edge seen in the wrong direction shows up as a status mismatch against a running bench model. Separate directed cases cover the clear write that coincides with an edge, a clear while a level is still active, a clear with zero data, and writes aimed at read-only offsets. A direction/value mix checks that the value read takes pin levels and register bits from the correct sources.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int REG_IDX_W = 4;
    localparam int BUS_W     = 32;

    typedef enum logic [REG_IDX_W-1:0] {
        REG_VAL  = 4'd0,
        REG_DIR  = 4'd1,
        REG_IEN  = 4'd2,
        REG_STS  = 4'd3,
        REG_PND  = 4'd4,
        REG_CLR  = 4'd5,
        REG_EDG  = 4'd6,
        REG_POL  = 4'd7,
        REG_VER  = 4'd8,
        REG_BOTH = 4'd9
    } reg_idx_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_async,
    output logic [W-1:0] smp,
    output logic [W-1:0] smp_prev
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d      = sy_q;
        sy_d.s1   = pin_async;
        sy_d.s2   = sy_q.s1;
        sy_d.prev = sy_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign smp      = sy_q.s2;
    assign smp_prev = sy_q.prev;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
    parameter int W = 8
) (
    input  logic [W-1:0] smp,
    input  logic [W-1:0] smp_prev,
    input  logic [W-1:0] edge_sel,
    input  logic [W-1:0] sense,
    input  logic [W-1:0] any_edge,
    output logic [W-1:0] evt
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise, fall, lvl_hit, edg_hit;
        always_comb begin
            rise    = smp[i] & ~smp_prev[i];
            fall    = ~smp[i] & smp_prev[i];
            lvl_hit = (smp[i] == sense[i]);
            if (any_edge[i]) edg_hit = rise | fall;
            else             edg_hit = sense[i] ? rise : fall;
            evt[i]  = edge_sel[i] ? edg_hit : lvl_hit;
        end
    end
endmodule

// File: rtl/gpio_evt_latch.sv
module gpio_evt_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] clr,
    output logic [W-1:0] sts
);
    logic [W-1:0] sts_d, sts_q;

    always_comb begin
        sts_d = (sts_q & ~clr) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= sts_d;
    end

    assign sts = sts_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int VERSION  = 3,
    parameter int ADDR_W   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq_out
);
    localparam int N = NUM_PINS;
    localparam bit HAS_ANY_EDGE = (VERSION >= 3);
    localparam logic [N-1:0] ANY_MASK = HAS_ANY_EDGE ? {N{1'b1}} : {N{1'b0}};

    typedef struct packed {
        logic [N-1:0]     val;
        logic [N-1:0]     dir;
        logic [N-1:0]     ien;
        logic [N-1:0]     edg;
        logic [N-1:0]     pol;
        logic [N-1:0]     both;
        logic [BUS_W-1:0] rdata;
    } ctrl_t;

    ctrl_t cr_d, cr_q;

    logic [REG_IDX_W-1:0] idx;
    logic [N-1:0] smp, smp_prev, evt, sts_q, clr_mask, ien_q, pend, lvl_view;
    logic [BUS_W-1:0] rd_mux;

    assign idx = bus_addr[REG_IDX_W+1:2];

    gpio_in_sync #(.W(N)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_async(pin_in),
        .smp(smp), .smp_prev(smp_prev)
    );

    gpio_trig_detect #(.W(N)) u_det (
        .smp(smp), .smp_prev(smp_prev), .edge_sel(cr_q.edg),
        .sense(cr_q.pol), .any_edge(cr_q.both), .evt(evt)
    );

    gpio_evt_latch #(.W(N)) u_lat (
        .clk(clk), .rst_n(rst_n), .evt(evt), .clr(clr_mask), .sts(sts_q)
    );

    always_comb begin
        ien_q    = cr_q.ien;
        pend     = sts_q & cr_q.ien;
        lvl_view = (cr_q.dir & smp) | (~cr_q.dir & cr_q.val);
        clr_mask = (bus_wr && idx == REG_CLR) ? bus_wdata[N-1:0] : '0;

        case (idx)
            REG_VAL:  rd_mux = BUS_W'(lvl_view);
            REG_DIR:  rd_mux = BUS_W'(cr_q.dir);
            REG_IEN:  rd_mux = BUS_W'(cr_q.ien);
            REG_STS:  rd_mux = BUS_W'(sts_q);
            REG_PND:  rd_mux = BUS_W'(pend);
            REG_EDG:  rd_mux = BUS_W'(cr_q.edg);
            REG_POL:  rd_mux = BUS_W'(cr_q.pol);
            REG_VER:  rd_mux = BUS_W'(VERSION);
            REG_BOTH: rd_mux = BUS_W'(cr_q.both);
            default:  rd_mux = '0;
        endcase

        cr_d = cr_q;
        if (bus_wr) begin
            case (idx)
                REG_VAL:  cr_d.val  = bus_wdata[N-1:0];
                REG_DIR:  cr_d.dir  = bus_wdata[N-1:0];
                REG_IEN:  cr_d.ien  = bus_wdata[N-1:0];
                REG_EDG:  cr_d.edg  = bus_wdata[N-1:0];
                REG_POL:  cr_d.pol  = bus_wdata[N-1:0];
                REG_BOTH: cr_d.both = bus_wdata[N-1:0] & ANY_MASK;
                default:  ;
            endcase
        end
        if (bus_rd) cr_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cr_q       <= '0;
            cr_q.dir   <= '1;
            cr_q.pol   <= '1;
        end else begin
            cr_q <= cr_d;
        end
    end

    assign bus_rdata = cr_q.rdata;
    assign pin_out   = cr_q.val;
    assign pin_oe    = ~cr_q.dir;
    assign irq_out   = |pend;
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
    parameter int NUM_PINS = 8,
    parameter int ADDR_W   = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [31:0]         bus_rdata,
    input logic [NUM_PINS-1:0] pin_out,
    input logic                irq_out,
    input logic [NUM_PINS-1:0] ien_q,
    input logic [NUM_PINS-1:0] evt,
    input logic [NUM_PINS-1:0] sts_q
);
    logic clr_wr;
    assign clr_wr = bus_wr && (bus_addr[5:2] == 4'd5);

    AST_STS_FALLS_ONLY_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(sts_q) & ~sts_q)) |-> $past(clr_wr)); // R9

    AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((sts_q & $past(evt)) == $past(evt))); // R7

    AST_IRQ_NEEDS_ENABLED_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (|(ien_q & sts_q))); // R8

    AST_NO_STATUS_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q == '0) |-> !irq_out); // R8

    AST_PIN_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(pin_out)); // R2

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R10
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .pin_out(pin_out),
    .irq_out(irq_out), .ien_q(ien_q), .evt(evt), .sts_q(sts_q)
);

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    localparam logic [3:0] A_VAL = 0, A_DIR = 1, A_IEN = 2, A_STS = 3, A_PND = 4,
                           A_CLR = 5, A_EDG = 6, A_POL = 7, A_VER = 8, A_BOTH = 9;

    logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [N-1:0] pin_in = '0, pin_out, pin_oe;
    logic irq_out;
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_ctrl #(.NUM_PINS(N), .VERSION(3), .ADDR_W(6)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] d);
        bus_wr = 1; bus_addr = {idx, 2'b00}; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [31:0] d);
        bus_rd = 1; bus_addr = {idx, 2'b00};
        @(posedge clk); @(negedge clk);
        bus_rd = 0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] rotl(input logic [7:0] x, input int n);
        logic [15:0] t;
        t = {x, x} << n;
        return t[15:8];
    endfunction

    function automatic logic [7:0] lvl_act(input logic [7:0] v, edg, pol);
        return ~edg & ~(v ^ pol);
    endfunction

    function automatic logic [7:0] edge_ev(input logic [7:0] v, p, edg, pol, both);
        return edg & ((both & (v ^ p)) | (~both & pol & v & ~p) | (~both & ~pol & ~v & p));
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [7:0] edg, pol, both, en, exp, p, v;

        idle(3);
        rst_n = 1;
        idle(2);

        // R1 reset state
        rd(A_DIR, d);  chk("R1 dir", d, 32'hFF);
        rd(A_IEN, d);  chk("R1 enable", d, 0);
        rd(A_EDG, d);  chk("R1 trigger-kind", d, 0);
        rd(A_POL, d);  chk("R1 sense", d, 32'hFF);
        rd(A_BOTH, d); chk("R1 any-edge", d, 0);
        rd(A_STS, d);  chk("R1 status", d, 0);
        chk("R1 pin_oe", pin_oe, 0);
        chk("R1 pin_out", pin_out, 0);
        chk("R1 irq", irq_out, 0);

        // R6 version and any-edge writability
        rd(A_VER, d); chk("R6 version", d, 3);
        wr(A_BOTH, 32'hA5); rd(A_BOTH, d); chk("R6 any-edge rw", d, 32'hA5);
        wr(A_BOTH, 0);

        // R2 / R3 direction and value mux
        wr(A_DIR, 32'h0F); wr(A_VAL, 32'hA5);
        chk("R2 pin_oe", pin_oe, 8'hF0);
        chk("R2 pin_out", pin_out, 8'hA5);
        pin_in = 8'h3C; idle(4);
        rd(A_VAL, d); chk("R3 value read mix", d, 32'hAC);
        pin_in = 8'hC3; idle(4);
        rd(A_VAL, d); chk("R3 value read mix 2", d, 32'hA3);
        chk("R2 pin_out unaffected by pins", pin_out, 8'hA5);
        wr(A_DIR, 32'hFF);
        pin_in = 0; idle(4);
        wr(A_CLR, 32'hFF);

        // R4 R5 R6 R8 sweep
        p = 0;
        for (int c = 0; c < 8; c++) begin
            edg  = rotl(8'hCC, c);
            pol  = rotl(8'hAA, c) ^ (c[0] ? 8'hFF : 8'h00);
            both = rotl(8'hF0, c);
            en   = 8'h5A ^ 8'(c * 8'h13);
            wr(A_EDG, edg); wr(A_POL, pol); wr(A_BOTH, both); wr(A_IEN, en);
            idle(4);
            wr(A_CLR, 32'hFF);
            exp = lvl_act(p, edg, pol);
            for (int s = 0; s < 12; s++) begin
                v = 8'(s * 8'h3B + c * 8'h17 + 8'h29);
                pin_in = v; idle(5);
                exp = exp | edge_ev(v, p, edg, pol, both) | lvl_act(v, edg, pol);
                p = v;
                rd(A_STS, d); chk("R4 R5 R6 status", d, {24'h0, exp});
                rd(A_PND, d); chk("R8 pending", d, {24'h0, exp & en});
                chk("R8 irq", irq_out, |(exp & en));
            end
            // R9 writes to read-only offsets ignored
            wr(A_STS, 32'h00); wr(A_PND, 32'h00); wr(A_VER, 32'h77);
            rd(A_STS, d); chk("R9 status unchanged", d, {24'h0, exp});
            rd(A_VER, d); chk("R9 version unchanged", d, 3);
            // R7 zero clear has no effect; full clear leaves active levels
            wr(A_CLR, 0);
            rd(A_STS, d); chk("R7 zero clear", d, {24'h0, exp});
            wr(A_CLR, 32'hFF);
            exp = lvl_act(p, edg, pol);
            rd(A_STS, d); chk("R7 clear keeps active level", d, {24'h0, exp});
        end

        // R8 enable of zero masks every pin
        wr(A_EDG, 0); wr(A_POL, 32'hFF); pin_in = 8'hFF; idle(5);
        wr(A_IEN, 0); idle(1);
        chk("R8 irq masked", irq_out, 0);
        rd(A_PND, d); chk("R8 pending masked", d, 0);
        wr(A_IEN, 32'h01); idle(1);
        chk("R8 irq enabled", irq_out, 1);

        // R7 edge coinciding with clear wins
        wr(A_IEN, 0);
        pin_in = 0; wr(A_EDG, 32'h01); wr(A_POL, 32'hFF); wr(A_BOTH, 0); idle(5);
        wr(A_CLR, 32'hFF);
        rd(A_STS, d); chk("R7 idle status", d, 0);
        pin_in = 8'h01;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        wr(A_CLR, 32'h01);
        rd(A_STS, d); chk("R7 edge beats clear", d, 32'h01);
        wr(A_CLR, 32'h01);
        rd(A_STS, d); chk("R7 clear after edge", d, 0);

        // R5 falling edge on sense 0
        wr(A_POL, 32'hFE); idle(2);
        pin_in = 8'h00; idle(5);
        rd(A_STS, d); chk("R5 falling edge", d & 32'h01, 32'h01);

        finish_run();
    end
endmodule